// File: doc/BRIEF.md
# Flash-to-FPGA Boot Configuration Loader

This block runs in the small support device that sits between a byte-wide parallel flash and a large FPGA. After reset it restarts the FPGA's configuration logic, waits until the FPGA reports that it is ready, and then moves a bitstream out of flash into the FPGA's parallel configuration port one byte at a time. Each byte travels on an 8-bit bus that is also wired to the flash data pins and to a seven-segment display. The loader never drives that bus while data is moving. It only opens the flash onto the bus and strobes the FPGA, which picks the byte up on the rising edge of the configuration clock.

A set of switches is wired to the top flash address bits, so the switch setting at power-up selects which stored image is loaded. The loader takes the switch value while the program pulse is low and keeps it for the whole transfer. Each image starts at offset zero of its region. When the FPGA raises done, the loader releases the flash and the bus. If done never arrives within the byte limit, or if the FPGA pulls init low during the transfer, the loader takes over the bus and shows a fault pattern on the display.

Top module: `boot_cfg_loader`

## Requirements
- R1: During reset and right after it, prog_n, flash_ce_n, flash_oe_n, cfg_cs_n and cfg_wr_n are high, cfg_clk and seg_oe are low, and mode_sel is held at 0 (the parallel configuration mode) at all times.
- R2: After reset is released, prog_n goes low exactly once for PROG_CYC clock cycles. The flash stays disabled until init_n has been seen high after that pulse.
- R3: flash_addr is {region, offset}. The region is the sw_sel value captured while prog_n is low. The offset starts at 0 and rises by one per transferred byte. Switch changes after the program pulse do not change the region.
- R4: For every byte, the flash is enabled with a stable address for RD_WAIT cycles before cfg_cs_n and cfg_wr_n go low. cfg_clk is then high for one cycle with cfg_cs_n, cfg_wr_n and flash_oe_n low and the address unchanged, so the FPGA receives flash byte {region, n} as the n-th byte.
- R5: cfg_clk does not rise while busy was high in the cycle before. The pending byte is held, not dropped and not repeated.
- R6: One cycle after done is seen high during a transfer, flash_ce_n and flash_oe_n are high, seg_oe is low and cfg_cs_n and cfg_wr_n are high. No further cfg_clk pulse occurs, so the FPGA receives exactly the bytes it needed when done arrives within the read wait that follows the last byte.
- R7: Suppose MAX_BYTES bytes have been clocked and done is still low at the end of the read wait that follows. The loader then disables the flash, drives seg_oe high with seg_data = LIMIT_CODE (default 8'h79), and stays in that state until reset, even if done rises later.
- R8: If done is high in the same cycle as the byte-limit decision, done wins: the bus is released and no fault code appears.
- R9: If init_n goes low while bytes are being transferred, the loader stops and shows seg_data = INIT_CODE (default 8'h71) with seg_oe high. No further byte is clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_sel | input | SEL_W | Switch setting, selects the image region |
| init_n | input | 1 | FPGA ready / error status, active low |
| done | input | 1 | FPGA configuration-complete status |
| busy | input | 1 | FPGA cannot accept a byte this cycle |
| flash_addr | output | ADDR_W | Flash byte address {region, offset} |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| prog_n | output | 1 | FPGA configuration restart, active low |
| cfg_cs_n | output | 1 | FPGA configuration-port select, active low |
| cfg_wr_n | output | 1 | FPGA configuration-port write, active low |
| cfg_clk | output | 1 | FPGA configuration clock; the byte is taken on its rise |
| mode_sel | output | 1 | FPGA mode-select pin, 0 selects parallel loading |
| seg_oe | output | 1 | Loader drives the shared bus (fault display only) |
| seg_data | output | SEG_W | Fault pattern placed on the shared bus |

## Verification
Two decisions can land in the same cycle. One is the end of the read wait after the MAX_BYTES-th byte, where the limit fault is decided. The other is the arrival of done. The bench model raises done a chosen number of clock edges after the last byte, exactly in that cycle and once one cycle too late. The first case must end with the bus released and no fault pattern. The second must show the limit code with the same byte count. Busy is also toggled on patterns that collide with the strobe cycle, and the model counts any clock rise it sees while busy is high.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

  typedef enum logic [2:0] {
    ST_BOOT   = 3'd0,
    ST_PROG   = 3'd1,
    ST_INIT   = 3'd2,
    ST_FETCH  = 3'd3,
    ST_STROBE = 3'd4,
    ST_ADV    = 3'd5,
    ST_DONE   = 3'd6,
    ST_FAULT  = 3'd7
  } ldr_state_e;

  typedef enum logic {
    FLT_LIMIT = 1'b0,
    FLT_INIT  = 1'b1
  } fault_kind_e;

endpackage

// File: rtl/boot_cfg_timer.sv
module boot_cfg_timer #(
  parameter int TMR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? (load_val - 1'b1) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/boot_cfg_addr.sv
module boot_cfg_addr #(
  parameter int ADDR_W    = 18,
  parameter int SEL_W     = 4,
  parameter int MAX_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              step,
  input  logic [SEL_W-1:0]  sw_sel,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              limit_hit
);

  localparam int OFF_W = ADDR_W - SEL_W;
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic [SEL_W-1:0] region_q;
  logic [OFF_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv_en;

  always_comb begin
    adv_en = capture || step;
    off_d  = capture ? '0 : off_q + 1'b1;
    cnt_d  = capture ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= '0;
    end else if (capture) begin
      region_q <= sw_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      cnt_q <= '0;
    end else if (adv_en) begin
      off_q <= off_d;
      cnt_q <= cnt_d;
    end
  end

  assign flash_addr = {region_q, off_q};
  assign limit_hit  = (cnt_q == CNT_W'(MAX_BYTES));

endmodule

// File: rtl/boot_cfg_seq.sv
module boot_cfg_seq
  import boot_cfg_pkg::*;
#(
  parameter int PROG_CYC = 4,
  parameter int RD_WAIT  = 3,
  parameter int TMR_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_n,
  input  logic             done,
  input  logic             busy,
  input  logic             tmr_expired,
  input  logic             limit_hit,
  output ldr_state_e       state_q,
  output fault_kind_e      fault_q,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             capture,
  output logic             step
);

  ldr_state_e  state_d;
  fault_kind_e fault_d;
  logic        fault_en;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    capture = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_BOOT:   state_d = ST_PROG;
      ST_PROG: begin
        capture = 1'b1;
        if (tmr_expired) state_d = ST_INIT;
      end
      ST_INIT:   if (init_n) state_d = ST_FETCH;
      ST_FETCH: begin
        if (done) begin
          state_d = ST_DONE;
        end else if (!init_n) begin
          state_d = ST_FAULT;
          fault_d = FLT_INIT;
        end else if (tmr_expired) begin
          if (limit_hit) begin
            state_d = ST_FAULT;
            fault_d = FLT_LIMIT;
          end else begin
            state_d = ST_STROBE;
          end
        end
      end
      ST_STROBE: begin
        if (done) begin
          state_d = ST_DONE;
        end else if (!init_n) begin
          state_d = ST_FAULT;
          fault_d = FLT_INIT;
        end else if (!busy) begin
          state_d = ST_ADV;
        end
      end
      ST_ADV: begin
        step = 1'b1;
        if (done) begin
          state_d = ST_DONE;
        end else if (!init_n) begin
          state_d = ST_FAULT;
          fault_d = FLT_INIT;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_DONE:   state_d = ST_DONE;
      ST_FAULT:  state_d = ST_FAULT;
      default:   state_d = ST_BOOT;
    endcase
    fault_en = (state_d == ST_FAULT) && (state_q != ST_FAULT);
    tmr_load = ((state_d == ST_PROG) && (state_q != ST_PROG)) ||
               ((state_d == ST_FETCH) && (state_q != ST_FETCH));
    tmr_val  = (state_d == ST_PROG) ? TMR_W'(PROG_CYC) : TMR_W'(RD_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_LIMIT;
    end else if (fault_en) begin
      fault_q <= fault_d;
    end
  end

endmodule

// File: rtl/boot_cfg_pins.sv
module boot_cfg_pins
  import boot_cfg_pkg::*;
#(
  parameter int           SEG_W      = 8,
  parameter logic [SEG_W-1:0] LIMIT_CODE = 8'h79,
  parameter logic [SEG_W-1:0] INIT_CODE  = 8'h71,
  parameter logic         PAR_MODE   = 1'b0
) (
  input  ldr_state_e       state_q,
  input  fault_kind_e      fault_q,
  output logic             flash_ce_n,
  output logic             flash_oe_n,
  output logic             prog_n,
  output logic             cfg_cs_n,
  output logic             cfg_wr_n,
  output logic             cfg_clk,
  output logic             mode_sel,
  output logic             seg_oe,
  output logic [SEG_W-1:0] seg_data
);

  logic flash_on, port_on, faulted;

  always_comb begin
    flash_on   = (state_q == ST_FETCH) || (state_q == ST_STROBE) || (state_q == ST_ADV);
    port_on    = (state_q == ST_STROBE) || (state_q == ST_ADV);
    faulted    = (state_q == ST_FAULT);
    flash_ce_n = !flash_on;
    flash_oe_n = !flash_on;
    prog_n     = (state_q != ST_PROG);
    cfg_cs_n   = !port_on;
    cfg_wr_n   = !port_on;
    cfg_clk    = (state_q == ST_ADV);
    mode_sel   = PAR_MODE;
    seg_oe     = faulted;
    if (!faulted) begin
      seg_data = '0;
    end else if (fault_q == FLT_INIT) begin
      seg_data = INIT_CODE;
    end else begin
      seg_data = LIMIT_CODE;
    end
  end

endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
  import boot_cfg_pkg::*;
#(
  parameter int               ADDR_W      = 18,
  parameter int               SEL_W       = 4,
  parameter int               SEG_W       = 8,
  parameter int               MAX_BYTES   = 2 ** (ADDR_W - SEL_W),
  parameter int               PROG_CYC    = 4,
  parameter int               RD_WAIT     = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [SEG_W-1:0] LIMIT_CODE  = 8'h79,
  parameter logic [SEG_W-1:0] INIT_CODE   = 8'h71
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sw_sel,
  input  logic              init_n,
  input  logic              done,
  input  logic              busy,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              prog_n,
  output logic              cfg_cs_n,
  output logic              cfg_wr_n,
  output logic              cfg_clk,
  output logic              mode_sel,
  output logic              seg_oe,
  output logic [SEG_W-1:0]  seg_data
);

  localparam int TMR_MAX = (PROG_CYC > RD_WAIT) ? PROG_CYC : RD_WAIT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic             rst_sync_n;
  ldr_state_e       state_q;
  fault_kind_e      fault_q;
  logic             tmr_load, tmr_expired, capture, step, limit_hit;
  logic [TMR_W-1:0] tmr_val;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync_one
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_sync_n = sync_q;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  boot_cfg_seq #(
    .PROG_CYC (PROG_CYC),
    .RD_WAIT  (RD_WAIT),
    .TMR_W    (TMR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .init_n      (init_n),
    .done        (done),
    .busy        (busy),
    .tmr_expired (tmr_expired),
    .limit_hit   (limit_hit),
    .state_q     (state_q),
    .fault_q     (fault_q),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .capture     (capture),
    .step        (step)
  );

  boot_cfg_timer #(
    .TMR_W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  boot_cfg_addr #(
    .ADDR_W    (ADDR_W),
    .SEL_W     (SEL_W),
    .MAX_BYTES (MAX_BYTES)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .capture    (capture),
    .step       (step),
    .sw_sel     (sw_sel),
    .flash_addr (flash_addr),
    .limit_hit  (limit_hit)
  );

  boot_cfg_pins #(
    .SEG_W      (SEG_W),
    .LIMIT_CODE (LIMIT_CODE),
    .INIT_CODE  (INIT_CODE),
    .PAR_MODE   (1'b0)
  ) u_pins (
    .state_q    (state_q),
    .fault_q    (fault_q),
    .flash_ce_n (flash_ce_n),
    .flash_oe_n (flash_oe_n),
    .prog_n     (prog_n),
    .cfg_cs_n   (cfg_cs_n),
    .cfg_wr_n   (cfg_wr_n),
    .cfg_clk    (cfg_clk),
    .mode_sel   (mode_sel),
    .seg_oe     (seg_oe),
    .seg_data   (seg_data)
  );

endmodule

// File: rtl/boot_cfg_loader_chk.sv
module boot_cfg_loader_chk #(
  parameter int ADDR_W = 18,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              prog_n,
  input logic              cfg_cs_n,
  input logic              cfg_wr_n,
  input logic              cfg_clk,
  input logic              seg_oe
);

  // R5: a clock rise only follows a cycle in which busy was low
  a_r5_clk_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> !$past(busy));

  // R4: address is unchanged on the cycle the byte is clocked
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(flash_addr));

  // R4: clock high only with the port selected and the flash driving
  a_r4_strobe_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> (!cfg_cs_n && !cfg_wr_n && !flash_oe_n));

  // R6: done during a transfer releases flash and bus in the next cycle
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flash_ce_n) |=> (flash_ce_n && flash_oe_n && !seg_oe && !cfg_clk));

  // R6: loader and flash never drive the shared bus together
  a_r6_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_oe && !flash_oe_n));

  // R7: fault display holds and nothing else moves
  a_r7_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seg_oe |=> (seg_oe && flash_ce_n && !cfg_clk));

  // R3: region bits do not change while the flash stays enabled
  a_r3_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr[ADDR_W-1 -: SEL_W]));

  // R2: flash is disabled during the program pulse
  a_r2_flash_off_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> flash_ce_n);

endmodule

bind boot_cfg_loader boot_cfg_loader_chk #(
  .ADDR_W (ADDR_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .flash_addr (flash_addr),
  .flash_ce_n (flash_ce_n),
  .flash_oe_n (flash_oe_n),
  .prog_n     (prog_n),
  .cfg_cs_n   (cfg_cs_n),
  .cfg_wr_n   (cfg_wr_n),
  .cfg_clk    (cfg_clk),
  .seg_oe     (seg_oe)
);

// File: tb/test_boot_cfg_loader.sv
module test_boot_cfg_loader;

  localparam int ADDR_W   = 10;
  localparam int SEL_W    = 4;
  localparam int OFF_N    = 2 ** (ADDR_W - SEL_W);
  localparam int MAXB     = 40;
  localparam int PROG_CYC = 4;
  localparam int RD_WAIT  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [SEL_W-1:0]  sw_sel = '0;
  logic              init_n = 1'b1;
  logic              done = 1'b0;
  logic              busy = 1'b0;
  logic [ADDR_W-1:0] flash_addr;
  logic              flash_ce_n, flash_oe_n, prog_n, cfg_cs_n, cfg_wr_n, cfg_clk, mode_sel, seg_oe;
  logic [7:0]        seg_data;
  logic [7:0]        bus;
  logic [7:0]        fdata = 8'hxx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int img_len = 0, done_k = 0, drop_at = -1, busy_mod = 2;
  bit busy_en = 1'b0;
  int cap_cnt = 0, busy_viol = 0, prog_low = 0, init_cnt = 5, dly = 0, stable = 0;
  logic [7:0]        cap [0:63];
  logic [ADDR_W-1:0] last_a = '0;

  always #5 clk = ~clk;

  boot_cfg_loader #(
    .ADDR_W    (ADDR_W),
    .SEL_W     (SEL_W),
    .MAX_BYTES (MAXB),
    .PROG_CYC  (PROG_CYC),
    .RD_WAIT   (RD_WAIT)
  ) i_boot_cfg_loader (
    .clk (clk), .rst_n (rst_n), .sw_sel (sw_sel), .init_n (init_n), .done (done), .busy (busy),
    .flash_addr (flash_addr), .flash_ce_n (flash_ce_n), .flash_oe_n (flash_oe_n), .prog_n (prog_n),
    .cfg_cs_n (cfg_cs_n), .cfg_wr_n (cfg_wr_n), .cfg_clk (cfg_clk), .mode_sel (mode_sel),
    .seg_oe (seg_oe), .seg_data (seg_data)
  );

  function automatic logic [7:0] fval(int a);
    return 8'(a * 37 + (a >> 3)) ^ 8'hA5;
  endfunction

  assign bus = seg_oe ? seg_data : ((!flash_ce_n && !flash_oe_n) ? fdata : 8'hzz);

  always @(posedge clk) cyc <= cyc + 1;

  // FPGA configuration port: takes the bus on each clock rise
  always @(posedge cfg_clk) begin
    if (busy) busy_viol = busy_viol + 1;
    if (cap_cnt < 64) cap[cap_cnt] = bus;
    cap_cnt = cap_cnt + 1;
  end

  // flash with access time, FPGA status pins, busy pattern
  always @(negedge clk) begin
    if (flash_addr != last_a) begin
      last_a = flash_addr;
      stable = 0;
    end else if (stable < 255) begin
      stable = stable + 1;
    end
    fdata = (stable >= RD_WAIT - 1) ? fval(int'(last_a)) : 8'hxx;
    if (!prog_n) begin
      prog_low = prog_low + 1;
      init_cnt = 0;
      init_n = 1'b0;
      done = 1'b0;
      dly = 0;
    end else begin
      if (drop_at >= 0 && cap_cnt >= drop_at) init_n = 1'b0;
      else if (init_cnt < 5) init_cnt = init_cnt + 1;
      else init_n = 1'b1;
      if (img_len > 0 && cap_cnt >= img_len && !done) begin
        if (dly >= done_k) done = 1'b1;
        else dly = dly + 1;
      end
    end
    busy = busy_en && ((cyc % busy_mod) < (busy_mod / 2));
  end

  task automatic chk(string req, string what, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_boot(int s, int len, int k, int drop, bit ben, int bmod, bit flip);
    bit flipped = 1'b0;
    bit ended = 1'b0;
    img_len = len; done_k = k; drop_at = drop; busy_en = ben; busy_mod = bmod;
    sw_sel = 4'(s);
    rst_n = 1'b0;
    done = 1'b0; init_n = 1'b1; init_cnt = 5; dly = 0;
    repeat (3) @(negedge clk);
    cap_cnt = 0; busy_viol = 0; prog_low = 0;
    rst_n = 1'b1;
    for (int t = 0; t < 4000 && !ended; t++) begin
      @(negedge clk);
      if (flip && !flipped && cap_cnt >= 2) begin
        sw_sel = ~4'(s);
        flipped = 1'b1;
      end
      if ((done && flash_ce_n && prog_n && prog_low > 0) || seg_oe) ended = 1'b1;
    end
    chk("R2", "run ended", int'(ended), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_data(string req, int s, int n);
    int bad = 0;
    int first_a = 0, first_e = 0;
    for (int i = 0; i < n && i < 64; i++) begin
      if (cap[i] !== fval(s * OFF_N + i)) begin
        if (bad == 0) begin
          first_a = int'(cap[i]);
          first_e = int'(fval(s * OFF_N + i));
        end
        bad = bad + 1;
      end
    end
    chk(req, "first wrong byte", first_a, first_e);
    chk(req, "wrong byte count", bad, 0);
  endtask

  task automatic chk_released(string req);
    chk(req, "flash_ce_n", int'(flash_ce_n), 1);
    chk(req, "flash_oe_n", int'(flash_oe_n), 1);
    chk(req, "seg_oe", int'(seg_oe), 0);
    chk(req, "cfg_cs_n/wr_n", int'({cfg_cs_n, cfg_wr_n}), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int keep;
    repeat (2) @(negedge clk);
    // R1: idle pin levels while reset is held
    chk("R1", "prog_n", int'(prog_n), 1);
    chk("R1", "flash_ce_n/oe_n", int'({flash_ce_n, flash_oe_n}), 3);
    chk("R1", "cfg_cs_n/wr_n", int'({cfg_cs_n, cfg_wr_n}), 3);
    chk("R1", "cfg_clk", int'(cfg_clk), 0);
    chk("R1", "seg_oe", int'(seg_oe), 0);
    chk("R1", "mode_sel", int'(mode_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "prog_n after release", int'(prog_n), 1);

    // sweep every switch setting with varied length, done delay, busy, switch flips
    for (int s = 0; s < 16; s++) begin
      run_boot(s, 5 + s, s % 4, -1, (s % 2) == 0, 2 + (s % 4), (s % 3) == 0);
      chk("R2", "program pulse width", prog_low, PROG_CYC);
      chk("R6", "bytes received", cap_cnt, 5 + s);
      chk_data((s % 3) == 0 ? "R3" : "R4", s, 5 + s);
      chk("R5", "clock while busy", busy_viol, 0);
      chk_released("R6");
      chk("R1", "mode_sel during run", int'(mode_sel), 0);
      keep = cap_cnt;
      repeat (20) @(negedge clk);
      chk("R6", "no clock after done", cap_cnt, keep);
    end

    // byte limit reached, done never comes
    run_boot(5, 0, 0, -1, 1'b1, 3, 1'b0);
    chk("R7", "bytes before fault", cap_cnt, MAXB);
    chk("R7", "seg_oe", int'(seg_oe), 1);
    chk("R7", "seg_data", int'(seg_data), 8'h79);
    chk("R7", "flash_ce_n", int'(flash_ce_n), 1);
    chk_data("R4", 5, MAXB);
    done = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7", "fault held after late done", int'(seg_oe), 1);
    chk("R7", "no clock in fault", cap_cnt, MAXB);

    // done in the very cycle of the limit decision: done wins
    run_boot(3, MAXB, 3, -1, 1'b0, 2, 1'b0);
    chk("R8", "bytes", cap_cnt, MAXB);
    chk("R8", "no fault code", int'(seg_data), 0);
    chk_released("R8");

    // done one cycle too late: fault
    run_boot(3, MAXB, 4, -1, 1'b0, 2, 1'b0);
    chk("R8", "late done faults", int'(seg_oe), 1);
    chk("R7", "late done code", int'(seg_data), 8'h79);
    chk("R7", "late done bytes", cap_cnt, MAXB);

    // init drops during transfer
    run_boot(9, 30, 0, 7, 1'b1, 4, 1'b0);
    chk("R9", "bytes before init fault", cap_cnt, 7);
    chk("R9", "seg_oe", int'(seg_oe), 1);
    chk("R9", "seg_data", int'(seg_data), 8'h71);
    chk("R9", "flash_ce_n", int'(flash_ce_n), 1);
    repeat (20) @(negedge clk);
    chk("R9", "no clock after init fault", cap_cnt, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule